// File: doc/BRIEF.md
# ADC Serial Frame Controller

This block is the master side of a 16-clock serial link to a multichannel successive-approximation ADC. A single-cycle start request opens a frame. The block pulls the active-low chip select down and derives the serial clock from the system clock. It then runs exactly sixteen serial clock periods. During the frame it shifts a 12-bit control word out on its data output, most significant bit first. In the same frame it gathers the sixteen bits that the converter returns.

The returned word begins with two zero bits. A 2-bit channel tag follows, then the conversion result, MSB first. At reduced resolution the word is padded with trailing zeros. The result width is fixed at elaboration time to 8, 10 or 12 bits. When the frame closes, the block presents the channel number and the result with a one-cycle valid strobe. A frame-error flag accompanies the strobe if either leading bit came back as one. Chip select then stays high for a guaranteed idle gap before another frame can begin.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, cs_n is 1, sclk is 1, mosi is 0, res_valid is 0 and frame_err is 0.
- R2: A start pulse seen while idle drives cs_n low on the next clock. cs_n then stays low for exactly 32*HALF_DIV system clocks, and sclk makes exactly 16 falling edges in that time. Each sclk half period is HALF_DIV clocks, and sclk is high whenever cs_n is high.
- R3: mosi carries ctrl_word[11] first and ctrl_word[0] twelfth. Each bit is valid at the falling sclk edge of its bit time. Within a frame mosi changes only when sclk rises. mosi is 0 during bit times 13 to 16 and while idle.
- R4: miso is sampled once on each falling sclk edge, giving a 16-bit word. The first sample is the word's MSB (bit 15).
- R5: res_chan equals word bits [13:12], with bit 13 as the channel MSB.
- R6: res_data equals the RES_BITS bits that start at word bit 11 and run downward. The remaining 12-RES_BITS low bits are ignored.
- R7: res_valid is a single-cycle pulse, raised exactly once per frame, two clocks after the clock that takes the 16th sample.
- R8: frame_err is 1 together with res_valid when word bit 15 or bit 14 is 1. Otherwise it is 0.
- R9: A start pulse that arrives while a frame runs, or during the idle gap after a frame, is ignored. It causes no extra frame and does not change the control word being sent.
- R10: Between two frames, cs_n stays high for at least 2*HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame request, honoured only while idle |
| ctrl_word | input | 12 | Control word captured at frame start |
| miso | input | 1 | Serial data returned by the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial control data to the converter |
| res_valid | output | 1 | One-cycle strobe marking a finished frame |
| res_chan | output | 2 | Channel tag from the returned word |
| res_data | output | RES_BITS | Conversion result |
| frame_err | output | 1 | Leading bits of the returned word were not zero |

## Verification
A half-edge counter that slips by one either shortens or lengthens the frame, and that shows up in the same frame. The falling-edge count and the cs_n low time go wrong. Every returned field is then shifted by one bit, so channel and result come out wrong together on that frame's strobe. A transmit shifter that steps on the wrong edge moves the control bits the slave captures by one position. A state machine that accepts start outside idle produces a second frame or a shortened gap within a couple of SCLK periods.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CTRL_BITS  = 12;
  localparam int LEAD_BITS  = 2;
  localparam int CHAN_BITS  = 2;
  localparam int HALVES     = 2 * FRAME_BITS;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } link_state_t;
endpackage

// File: rtl/adc_sclk_seq.sv
module adc_sclk_seq
  import adc_frame_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic cs_n,
  output logic sclk,
  output logic load,
  output logic fall_tick,
  output logic rise_tick,
  output logic last_fall
);
  localparam int CW = $clog2(2 * HALF_DIV + 1);
  localparam int HW = $clog2(HALVES + 1);
  localparam logic [CW-1:0] HALF_END = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] GAP_END  = CW'(2 * HALF_DIV - 1);
  localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);
  localparam logic [HW-1:0] LAST_LOW  = HW'(HALVES - 2);

  link_state_t      state;
  logic [CW-1:0]    cnt;
  logic [HW-1:0]    half_idx;
  logic             half_end;

  assign half_end  = (state == ST_RUN) && (cnt == HALF_END);
  assign fall_tick = half_end && sclk;
  assign rise_tick = half_end && !sclk;
  assign last_fall = fall_tick && (half_idx == LAST_LOW);
  assign load      = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      half_idx <= '0;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt      <= '0;
          half_idx <= '0;
          sclk     <= 1'b1;
          if (start) begin
            state <= ST_RUN;
            cs_n  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (half_end) begin
            cnt      <= '0;
            sclk     <= ~sclk;
            half_idx <= half_idx + 1'b1;
            if (half_idx == LAST_HALF) begin
              state <= ST_GAP;
              cs_n  <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == GAP_END) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift
  import adc_frame_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [CTRL_BITS-1:0]  ctrl_word,
  input  logic                  fall_tick,
  input  logic                  rise_tick,
  input  logic                  last_fall,
  input  logic                  miso,
  output logic                  mosi,
  output logic                  word_done,
  output logic [FRAME_BITS-1:0] word
);
  localparam int PAD = FRAME_BITS - CTRL_BITS;

  logic [FRAME_BITS-1:0] tx_sr;
  logic [FRAME_BITS-2:0] rx_sr;

  assign mosi = tx_sr[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= {ctrl_word, {PAD{1'b0}}};
    end else if (rise_tick) begin
      tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr     <= '0;
      word      <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (fall_tick) begin
        rx_sr <= {rx_sr[FRAME_BITS-3:0], miso};
        if (last_fall) begin
          word      <= {rx_sr, miso};
          word_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_word_unpack.sv
module adc_word_unpack
  import adc_frame_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  word_done,
  input  logic [FRAME_BITS-1:0] word,
  output logic                  res_valid,
  output logic [CHAN_BITS-1:0]  res_chan,
  output logic [RES_BITS-1:0]   res_data,
  output logic                  frame_err
);
  localparam int LEAD_TOP = FRAME_BITS - 1;
  localparam int CHAN_TOP = FRAME_BITS - LEAD_BITS - 1;
  localparam int DATA_TOP = CHAN_TOP - CHAN_BITS;

  logic [LEAD_BITS-1:0] lead;
  logic [RES_BITS-1:0]  data_field;

  assign lead = word[LEAD_TOP -: LEAD_BITS];

  generate
    if (RES_BITS == DATA_TOP + 1) begin : g_full
      assign data_field = word[DATA_TOP:0];
    end else begin : g_padded
      assign data_field = word[DATA_TOP -: RES_BITS];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
      frame_err <= 1'b0;
    end else begin
      res_valid <= word_done;
      frame_err <= word_done && (lead != '0);
      if (word_done) begin
        res_chan <= word[CHAN_TOP -: CHAN_BITS];
        res_data <= data_field;
      end
    end
  end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int RES_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [11:0]          ctrl_word,
  input  logic                 miso,
  output logic                 cs_n,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 res_valid,
  output logic [1:0]           res_chan,
  output logic [RES_BITS-1:0]  res_data,
  output logic                 frame_err
);
  logic                  load;
  logic                  fall_tick;
  logic                  rise_tick;
  logic                  last_fall;
  logic                  word_done;
  logic [FRAME_BITS-1:0] word;

  adc_sclk_seq #(.HALF_DIV(HALF_DIV)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .load      (load),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick),
    .last_fall (last_fall)
  );

  adc_frame_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .ctrl_word (ctrl_word),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick),
    .last_fall (last_fall),
    .miso      (miso),
    .mosi      (mosi),
    .word_done (word_done),
    .word      (word)
  );

  adc_word_unpack #(.RES_BITS(RES_BITS)) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .word_done (word_done),
    .word      (word),
    .res_valid (res_valid),
    .res_chan  (res_chan),
    .res_data  (res_data),
    .frame_err (frame_err)
  );
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic res_valid,
  input logic frame_err
);
  localparam int GW = $clog2(2 * HALF_DIV + 2) + 1;
  localparam logic [GW-1:0] GAP_MIN = GW'(2 * HALF_DIV);
  localparam logic [GW-1:0] GAP_SAT = {GW{1'b1}};

  logic       sclk_q;
  logic [5:0] fall_cnt;
  logic [GW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b1;
      fall_cnt <= '0;
      hi_cnt   <= GAP_SAT;
    end else begin
      sclk_q <= sclk;
      if (cs_n) fall_cnt <= '0;
      else if (sclk_q && !sclk) fall_cnt <= fall_cnt + 1'b1;
      if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt != GAP_SAT) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R2: clock parks high outside a frame
  a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  // R2: sixteen falling edges per frame
  a_r2_sixteen_falls: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (fall_cnt == 6'd16));

  // R3: inside a frame the data line moves only with a rising clock
  a_r3_mosi_on_rise: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n) && !$stable(mosi)) |-> $rose(sclk));

  // R7: strobe lasts one cycle
  a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R8: error flag only alongside the strobe
  a_r8_err_with_valid: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> res_valid);

  // R10: minimum high time before a new frame
  a_r10_gap_min: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_cnt >= GAP_MIN));
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .res_valid (res_valid),
  .frame_err (frame_err)
);

// File: tb/adc_frame_ctrl_test.sv
`timescale 1ns/1ps
module adc_frame_ctrl_test;
  localparam int HALF_DIV = 4;
  localparam int RES = 12;
  localparam int NVEC = 6;
  // entry: {ctrl[11:0], lead[1:0], chan[1:0], result[11:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {12'hA5C, 2'b00, 2'd0, 12'h000},
    {12'h800, 2'b00, 2'd3, 12'hFFF},
    {12'h3C1, 2'b00, 2'd1, 12'h5A5},
    {12'hFFF, 2'b00, 2'd2, 12'h801},
    {12'h001, 2'b10, 2'd1, 12'h123},
    {12'h555, 2'b01, 2'd2, 12'hABC}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [11:0] ctrl_word = '0;
  logic miso = 1'b0;
  logic cs_n, sclk, mosi, res_valid, frame_err;
  logic [1:0] res_chan;
  logic [RES-1:0] res_data;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  adc_frame_ctrl #(.HALF_DIV(HALF_DIV), .RES_BITS(RES)) uut (
    .clk(clk), .rst(rst), .start(start), .ctrl_word(ctrl_word), .miso(miso),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .res_valid(res_valid),
    .res_chan(res_chan), .res_data(res_data), .frame_err(frame_err)
  );

  // slave model
  logic [15:0] sl_word = '0;
  logic [11:0] sl_ctrl;
  logic        sl_tail;
  int          sl_pos;
  int          sl_falls;

  always @(negedge cs_n) begin
    miso     <= sl_word[15];
    sl_pos   = 14;
    sl_falls = 0;
    sl_ctrl  = '0;
    sl_tail  = 1'b0;
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      sl_falls = sl_falls + 1;
      if (sl_falls <= 12) sl_ctrl = {sl_ctrl[10:0], mosi};
      else sl_tail = sl_tail | mosi;
      if (sl_pos >= 0) begin
        miso   <= sl_word[sl_pos];
        sl_pos = sl_pos - 1;
      end else begin
        miso <= 1'b0;
      end
    end
  end

  // port monitors, sampled on the falling system clock
  int low_cyc = 0;
  int hi_cyc = 0;
  int last_hi = 0;
  int frames = 0;
  int valids = 0;
  logic prev_cs = 1'b1;
  logic prev_valid = 1'b0;
  logic [1:0] got_chan;
  logic [RES-1:0] got_data;
  logic got_err;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        last_hi = hi_cyc;
        low_cyc = 0;
        frames++;
      end
      if (!cs_n) begin
        low_cyc++;
        hi_cyc = 0;
      end else begin
        hi_cyc++;
      end
      if (res_valid) begin
        valids++;
        got_chan = res_chan;
        got_data = res_data;
        got_err  = frame_err;
        if (prev_valid) chk(1'b0, "R7 valid wider than one cycle", 2, 1);
      end
      prev_cs    = cs_n;
      prev_valid = res_valid;
    end
  end

  task automatic wait_valid(input int v0);
    for (int i = 0; i < 4000 && valids == v0; i++) @(negedge clk);
  endtask

  task automatic set_slave(input logic [1:0] lead, input logic [1:0] chan,
                           input logic [11:0] res);
    logic [11:0] mask;
    mask = 12'hFFF >> RES;
    sl_word = {lead, chan, (res << (12 - RES)) | (12'hA5A & mask)};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v0;
    int f0;
    logic [11:0] vc;
    logic [1:0]  vl, vch;
    logic [11:0] vr;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    chk(sclk == 1'b1, "R1 sclk in reset", sclk, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(mosi == 1'b0, "R1 mosi after reset", mosi, 0);
    chk(res_valid == 1'b0 && frame_err == 1'b0, "R1 valid/err after reset",
        {res_valid, frame_err}, 0);
    chk(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);

    // vector table walk
    for (int k = 0; k < NVEC; k++) begin
      {vc, vl, vch, vr} = VEC[k];
      set_slave(vl, vch, vr);
      ctrl_word = vc;
      v0 = valids;
      f0 = frames;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(cs_n == 1'b0, "R2 cs_n low one clock after start", cs_n, 0);
      wait_valid(v0);
      chk(got_chan == vch, "R5 channel", got_chan, vch);
      chk(got_data == vr[11 -: RES], "R6 result", got_data, vr[11 -: RES]);
      chk(got_err == (vl != 2'b00), "R8 frame error", got_err, vl != 2'b00);
      chk(sl_ctrl == vc, "R3 control word seen by slave", sl_ctrl, vc);
      while (!cs_n) @(negedge clk);
      chk(sl_falls == 16, "R2 falling edge count", sl_falls, 16);
      chk(low_cyc == 32 * HALF_DIV, "R2 cs_n low time", low_cyc, 32 * HALF_DIV);
      chk(sl_tail == 1'b0, "R3 mosi zero in bit times 13-16", sl_tail, 0);
      chk(mosi == 1'b0, "R3 mosi zero when idle", mosi, 0);
      repeat (2 * HALF_DIV + 2) @(negedge clk);
      chk(valids == v0 + 1 && frames == f0 + 1, "R7 one strobe per frame",
          valids - v0, 1);
    end

    // R9: start during a running frame
    set_slave(2'b00, 2'd2, 12'h6B3);
    ctrl_word = 12'h9C3;
    v0 = valids;
    f0 = frames;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5 * HALF_DIV) @(negedge clk);
    ctrl_word = 12'h123;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ctrl_word = 12'h0F0;
    wait_valid(v0);
    chk(sl_ctrl == 12'h9C3, "R9 mid-frame start keeps control word", sl_ctrl, 12'h9C3);
    while (!cs_n) @(negedge clk);
    // R9: start during the gap
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3 * HALF_DIV) begin
      if (!cs_n) chk(1'b0, "R9 start in gap opened a frame", cs_n, 1);
      @(negedge clk);
    end
    chk(frames == f0 + 1 && valids == v0 + 1, "R9 no extra frame", frames - f0, 1);

    // R10: start held high back to back
    set_slave(2'b00, 2'd1, 12'h3E7);
    ctrl_word = 12'h7A1;
    f0 = frames;
    v0 = valids;
    start = 1'b1;
    while (frames < f0 + 2) @(negedge clk);
    start = 1'b0;
    chk(last_hi >= 2 * HALF_DIV, "R10 gap between frames", last_hi, 2 * HALF_DIV);
    wait_valid(v0 + 1);
    chk(got_chan == 2'd1 && got_data == 12'h3E7 >> (12 - RES),
        "R4 back-to-back sample", got_data, 12'h3E7 >> (12 - RES));
    while (!cs_n) @(negedge clk);
    repeat (4 * HALF_DIV) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule